// File: doc/BRIEF.md
# Microcycle Register Writeback

This block is the register stage at the end of a 16-bit microcoded datapath's microcycle. It takes the results that the datapath has already worked out: the ALU output, the bus value and the ALU carry. It then commits them to the working registers in one clock edge. The load enables, the ALU-mode flag, the T-source flag and the task's RAM-related flag are all decoded upstream. The block keeps a temporary register, a latch register, a memory-link register, a latched carry bit and a control-store address latch.

Each task owns a bank number, and the bank selects one set of scratch registers. Scratch entry 0 of a bank is a write-only shadow of the memory-link register. A read of index 0 therefore returns the link register itself. Any other index returns what a store placed there. A store copies the link register into the selected scratch entry of the current task's bank. The scratch array sits in a simple dual-port memory with one write port and a registered read, so that it can map onto block RAM.

Top module: `uc_writeback`

## Requirements
- R1: A synchronous active-high reset clears `t_q`, `l_q`, `m_q`, `carry_q`, `caddr_q` and `rd_data` to zero.
- R2: On an edge with `ld_t`=1, `t_q` takes `alu_res` if `t_sel_alu`=1 and `bus_val` if `t_sel_alu`=0. With `ld_t`=0, `t_q` holds.
- R3: On an edge with `ld_t`=1, `caddr_q` takes `alu_res`. Otherwise it holds.
- R4: On an edge with `ld_l`=1, `l_q` takes `alu_res`. Otherwise it holds.
- R5: On an edge with `ld_l`=1, `carry_q` becomes 0 when `alu_logic`=1 and takes `alu_cout` when `alu_logic`=0. With `ld_l`=0, it holds whatever `alu_logic` and `alu_cout` are.
- R6: `m_q` takes `alu_res` only on an edge with `ld_l`=1 and `task_ram`=1. In that case scratch entry 0 of bank `task_bank` is written too. With `ld_l`=0, `task_ram` has no effect and `m_q` holds.
- R7: Scratch entry 0 is write-only. After an edge with `rd_sel`=0, `rd_data` equals the `m_q` value from before that edge.
- R8: On an edge with `st_s`=1, scratch entry `{task_bank, rd_sel}` takes the `m_q` value from before that edge. If `st_s` and the entry-0 write of R6 fall on the same edge, the store wins.
- R9: After an edge with `rd_sel`≠0, `rd_data` equals scratch entry `{task_bank, rd_sel}` as it stood before that edge. A store to the same entry on that edge is not yet visible (read-first), and each bank keeps its own entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_res | input | DW | ALU result of this microcycle |
| bus_val | input | DW | Bus value of this microcycle |
| alu_cout | input | 1 | ALU carry out |
| ld_t | input | 1 | Load temporary register and address latch |
| ld_l | input | 1 | Load latch register and carry |
| alu_logic | input | 1 | 1 = logic ALU function, 0 = arithmetic |
| t_sel_alu | input | 1 | 1 = T source is ALU, 0 = bus |
| task_ram | input | 1 | Current task is RAM-related |
| task_bank | input | $clog2(BANKS) | Scratch bank of the current task |
| rd_sel | input | $clog2(REGS) | Scratch index for read and store |
| st_s | input | 1 | Store `m_q` into the selected scratch entry |
| t_q | output | DW | Temporary register |
| l_q | output | DW | Latch register |
| m_q | output | DW | Memory-link register |
| carry_q | output | 1 | Latched ALU carry |
| caddr_q | output | DW | Control-store address latch |
| rd_data | output | DW | Registered scratch read |

## Verification
The bench fills every non-zero entry of every bank through stores and reads each one back. A design that mixed up the bank bits, or that let entry 0 shadow the array, would return another entry's value. It then sweeps all 64 combinations of the six control bits with random data. This catches a carry that latches on logic operations, a link register that follows `task_ram` without `ld_l`, and a T register that picks the wrong source. Stores that read the entry they write show whether the read is read-first; a write-first design would return the new value one cycle early. A second reset in mid-run confirms that every output clears.

// File: rtl/uc_wb_pkg.sv
package uc_wb_pkg;
  typedef enum logic {
    TSRC_BUS = 1'b0,
    TSRC_ALU = 1'b1
  } tsrc_e;

  typedef enum logic {
    ALU_ARITH = 1'b0,
    ALU_LOGIC = 1'b1
  } alu_mode_e;
endpackage

// File: rtl/uc_wb_tpath.sv
module uc_wb_tpath
  import uc_wb_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_t,
  input  tsrc_e         tsrc,
  input  logic [DW-1:0] alu_res,
  input  logic [DW-1:0] bus_val,
  output logic [DW-1:0] t_q,
  output logic [DW-1:0] caddr_q
);
  logic [DW-1:0] t_next;

  always_comb begin
    t_next = (tsrc == TSRC_ALU) ? alu_res : bus_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q     <= '0;
      caddr_q <= '0;
    end else if (ld_t) begin
      t_q     <= t_next;
      caddr_q <= alu_res;
    end
  end
endmodule

// File: rtl/uc_wb_lpath.sv
module uc_wb_lpath
  import uc_wb_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_l,
  input  alu_mode_e     mode,
  input  logic          task_ram,
  input  logic          alu_cout,
  input  logic [DW-1:0] alu_res,
  output logic [DW-1:0] l_q,
  output logic          carry_q,
  output logic [DW-1:0] m_q,
  output logic          link_we
);
  assign link_we = ld_l & task_ram;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_q     <= '0;
      carry_q <= 1'b0;
      m_q     <= '0;
    end else begin
      if (ld_l) begin
        l_q     <= alu_res;
        carry_q <= (mode == ALU_LOGIC) ? 1'b0 : alu_cout;
      end
      if (link_we) begin
        m_q <= alu_res;
      end
    end
  end
endmodule

// File: rtl/uc_wb_scratch.sv
module uc_wb_scratch #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/uc_writeback.sv
module uc_writeback
  import uc_wb_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned BANKS = 8,
  parameter int unsigned REGS  = 32,
  localparam int unsigned BW   = $clog2(BANKS),
  localparam int unsigned SW   = $clog2(REGS),
  localparam int unsigned AW   = BW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] alu_res,
  input  logic [DW-1:0] bus_val,
  input  logic          alu_cout,
  input  logic          ld_t,
  input  logic          ld_l,
  input  logic          alu_logic,
  input  logic          t_sel_alu,
  input  logic          task_ram,
  input  logic [BW-1:0] task_bank,
  input  logic [SW-1:0] rd_sel,
  input  logic          st_s,
  output logic [DW-1:0] t_q,
  output logic [DW-1:0] l_q,
  output logic [DW-1:0] m_q,
  output logic          carry_q,
  output logic [DW-1:0] caddr_q,
  output logic [DW-1:0] rd_data
);
  tsrc_e         tsrc;
  alu_mode_e     mode;
  logic          link_we;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          sel0_q;
  logic [DW-1:0] link_copy_q;

  assign tsrc = tsrc_e'(t_sel_alu);
  assign mode = alu_mode_e'(alu_logic);

  uc_wb_tpath #(.DW(DW)) u_tpath (
    .clk     (clk),
    .rst     (rst),
    .ld_t    (ld_t),
    .tsrc    (tsrc),
    .alu_res (alu_res),
    .bus_val (bus_val),
    .t_q     (t_q),
    .caddr_q (caddr_q)
  );

  uc_wb_lpath #(.DW(DW)) u_lpath (
    .clk      (clk),
    .rst      (rst),
    .ld_l     (ld_l),
    .mode     (mode),
    .task_ram (task_ram),
    .alu_cout (alu_cout),
    .alu_res  (alu_res),
    .l_q      (l_q),
    .carry_q  (carry_q),
    .m_q      (m_q),
    .link_we  (link_we)
  );

  // single write port: an explicit store wins over the entry-0 shadow write
  always_comb begin
    mem_we = st_s | link_we;
    if (st_s) begin
      mem_waddr = {task_bank, rd_sel};
      mem_wdata = m_q;
    end else begin
      mem_waddr = {task_bank, {SW{1'b0}}};
      mem_wdata = alu_res;
    end
  end

  uc_wb_scratch #(.DW(DW), .DEPTH(BANKS * REGS)) u_scratch (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr ({task_bank, rd_sel}),
    .rdata (mem_rdata)
  );

  // entry 0 is never read from the array; it reads back the link register
  always_ff @(posedge clk) begin
    if (rst) begin
      sel0_q      <= 1'b1;
      link_copy_q <= '0;
    end else begin
      sel0_q      <= (rd_sel == '0);
      link_copy_q <= m_q;
    end
  end

  assign rd_data = sel0_q ? link_copy_q : mem_rdata;
endmodule

// File: rtl/uc_writeback_chk.sv
module uc_writeback_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] alu_res,
  input logic [DW-1:0] bus_val,
  input logic          alu_cout,
  input logic          ld_t,
  input logic          ld_l,
  input logic          alu_logic,
  input logic          t_sel_alu,
  input logic          task_ram,
  input logic [SW-1:0] rd_sel,
  input logic [DW-1:0] t_q,
  input logic [DW-1:0] l_q,
  input logic [DW-1:0] m_q,
  input logic          carry_q,
  input logic [DW-1:0] caddr_q,
  input logic [DW-1:0] rd_data
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (t_q == '0 && l_q == '0 && m_q == '0 && !carry_q && caddr_q == '0 && rd_data == '0)); // R1
  AST_T_FROM_ALU: assert property (@(posedge clk) disable iff (rst)
    (ld_t && t_sel_alu) |=> t_q == $past(alu_res)); // R2
  AST_T_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
    (ld_t && !t_sel_alu) |=> t_q == $past(bus_val)); // R2
  AST_T_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ld_t |=> $stable(t_q)); // R2
  AST_CADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_t |=> caddr_q == $past(alu_res)); // R3
  AST_L_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_l |=> l_q == $past(alu_res)); // R4
  AST_CARRY_LOGIC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ld_l && alu_logic) |=> !carry_q); // R5
  AST_CARRY_ARITH: assert property (@(posedge clk) disable iff (rst)
    (ld_l && !alu_logic) |=> carry_q == $past(alu_cout)); // R5
  AST_CARRY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ld_l |=> $stable(carry_q)); // R5
  AST_LINK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ld_l && task_ram) |=> m_q == $past(alu_res)); // R6
  AST_LINK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(ld_l && task_ram) |=> $stable(m_q)); // R6
  AST_ENTRY0_READS_LINK: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == '0) |=> rd_data == $past(m_q)); // R7
endmodule

bind uc_writeback uc_writeback_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .alu_res   (alu_res),
  .bus_val   (bus_val),
  .alu_cout  (alu_cout),
  .ld_t      (ld_t),
  .ld_l      (ld_l),
  .alu_logic (alu_logic),
  .t_sel_alu (t_sel_alu),
  .task_ram  (task_ram),
  .rd_sel    (rd_sel),
  .t_q       (t_q),
  .l_q       (l_q),
  .m_q       (m_q),
  .carry_q   (carry_q),
  .caddr_q   (caddr_q),
  .rd_data   (rd_data)
);

// File: tb/test_uc_writeback.sv
`timescale 1ns/1ps
module test_uc_writeback;
  localparam int DW = 16;
  localparam int BANKS = 8;
  localparam int REGS = 32;
  localparam int BW = $clog2(BANKS);
  localparam int SW = $clog2(REGS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] alu_res = '0, bus_val = '0;
  logic          alu_cout = 0, ld_t = 0, ld_l = 0, alu_logic = 0, t_sel_alu = 0, task_ram = 0, st_s = 0;
  logic [BW-1:0] task_bank = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [DW-1:0] t_q, l_q, m_q, caddr_q, rd_data;
  logic          carry_q;

  always #2.5 clk = ~clk;

  uc_writeback #(.DW(DW), .BANKS(BANKS), .REGS(REGS)) i_uc_writeback (
    .clk(clk), .rst(rst), .alu_res(alu_res), .bus_val(bus_val), .alu_cout(alu_cout),
    .ld_t(ld_t), .ld_l(ld_l), .alu_logic(alu_logic), .t_sel_alu(t_sel_alu),
    .task_ram(task_ram), .task_bank(task_bank), .rd_sel(rd_sel), .st_s(st_s),
    .t_q(t_q), .l_q(l_q), .m_q(m_q), .carry_q(carry_q), .caddr_q(caddr_q), .rd_data(rd_data)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [DW-1:0] eT, eL, eM, eA, eRd;
  logic eC;
  bit rd_known;
  logic [DW-1:0] mm [BANKS][REGS];
  bit mv [BANKS][REGS];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one microcycle: update the model from the present inputs, clock, then compare
  task automatic tick(input string rtag);
    if (rst) begin
      eT = '0; eL = '0; eM = '0; eA = '0; eC = 0; eRd = '0; rd_known = 1;
    end else begin
      if (rd_sel == '0) begin eRd = eM; rd_known = 1; end
      else begin eRd = mm[task_bank][rd_sel]; rd_known = mv[task_bank][rd_sel]; end
      if (st_s) begin mm[task_bank][rd_sel] = eM; mv[task_bank][rd_sel] = 1; end
      if (ld_t) begin eT = t_sel_alu ? alu_res : bus_val; eA = alu_res; end
      if (ld_l) begin eL = alu_res; eC = alu_logic ? 1'b0 : alu_cout; end
      if (ld_l && task_ram) eM = alu_res;
    end
    @(posedge clk); #1;
    if (rst) begin
      chk("R1 t_q", t_q, '0); chk("R1 l_q", l_q, '0); chk("R1 m_q", m_q, '0);
      chk("R1 carry_q", {15'b0, carry_q}, '0); chk("R1 caddr_q", caddr_q, '0);
      chk("R1 rd_data", rd_data, '0);
    end else begin
      chk("R2 t_q", t_q, eT);
      chk("R3 caddr_q", caddr_q, eA);
      chk("R4 l_q", l_q, eL);
      chk("R5 carry_q", {15'b0, carry_q}, {15'b0, eC});
      chk("R6 m_q", m_q, eM);
      if (rd_known) chk(rtag, rd_data, eRd);
    end
  endtask

  task automatic idle();
    ld_t = 0; ld_l = 0; st_s = 0; task_ram = 0; alu_logic = 0; t_sel_alu = 0; alu_cout = 0;
  endtask

  initial begin
    for (int b = 0; b < BANKS; b++) for (int s = 0; s < REGS; s++) mv[b][s] = 0;
    #1;
    tick("R1 rd"); tick("R1 rd");
    rst = 0;
    // fill every non-zero entry of every bank through the link register
    for (int b = 0; b < BANKS; b++) begin
      for (int s = 1; s < REGS; s++) begin
        idle(); task_bank = BW'(b); rd_sel = '0;
        ld_l = 1; task_ram = 1; alu_res = DW'(16'h1000 * b + 16'h0101 * s); alu_logic = 1;
        tick("R7 rd_data entry0");
        idle(); st_s = 1; rd_sel = SW'(s);
        tick("R9 rd_data store read-first (R8)");
      end
    end
    // read everything back with distinct bank contents
    for (int b = 0; b < BANKS; b++) begin
      for (int s = 0; s < REGS; s++) begin
        idle(); task_bank = BW'(b); rd_sel = SW'(s);
        tick(s == 0 ? "R7 rd_data entry0" : "R9 rd_data readback of R8 store");
      end
    end
    // sweep all control combinations with random data
    for (int c = 0; c < 64; c++) begin
      for (int k = 0; k < 8; k++) begin
        ld_t = c[0]; ld_l = c[1]; alu_logic = c[2]; t_sel_alu = c[3]; task_ram = c[4]; st_s = c[5];
        alu_res = DW'($urandom); bus_val = DW'($urandom); alu_cout = 1'($urandom);
        task_bank = BW'($urandom); rd_sel = (k == 0) ? '0 : SW'($urandom);
        tick(rd_sel == '0 ? "R7 rd_data sweep" : "R9 rd_data sweep (R8)");
      end
    end
    // reset in mid-run
    idle(); alu_res = 16'hFFFF; ld_t = 1; ld_l = 1; task_ram = 1; alu_cout = 1;
    tick("R7 rd");
    rst = 1; tick("R1 rd"); rst = 0; idle(); rd_sel = '0;
    tick("R7 rd_data after reset");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule